// File: doc/BRIEF.md
# Decade Timebase Sample-Clock Generator

This block turns a 100 MHz system clock into a one-cycle sample-enable strobe, `sample_stb`. A 5-bit timebase code picks the strobe rate. The rate comes from a 1-2-5 decade series of division ratios, from 1 up to one million. Two codes leave the divider aside. One paces the strobe from an external clock input. The other fires the strobe once for each manual step request, which suits reading back a capture memory one word at a time.

A falling-edge option moves the strobe to the other half of the sampling period. For divided rates, the strobe is delayed by half the divided period. For the external clock, the strobe follows that clock's falling edges instead of its rising edges. In step mode the option has no effect. Whenever the code changes, or reset is released, the divider restarts, so the first strobe keeps a fixed phase relative to the change.

Top module: `sample_timebase`

## Requirements
- R1: While `rst_n` is low, `sample_stb` is 0.
- R2: Codes 0 to 18 select the division ratio N from the series 1, 2, 5, 10, 20, 50, ... 1000000, in rising order: code c gives (1, 2 or 5, for c mod 3 = 0, 1 or 2) times 10^(c div 3). With `fall_edge` = 0, let E be the edge that first samples the new code (or the first edge after reset is released). Strobes are then high in the cycles that follow edges E+1, E+1+N, E+1+2N, and so on.
- R3: Code 0 (N = 1) gives a strobe in every cycle after E+1, whatever the value of `fall_edge`.
- R4: Every code from 19 to 29 divides by 2.
- R5: With `fall_edge` = 1 and a divided code, every strobe is delayed by floor(N/2) cycles compared with R2.
- R6: Code 30 selects `ext_clk`. Suppose a rising edge of `ext_clk` is first sampled at edge k, and `fall_edge` = 0. Then exactly one strobe is high, in the cycle after edge k+2, and a falling edge gives no strobe.
- R7: Code 30 with `fall_edge` = 1 strobes only on falling edges of `ext_clk`, with the same latency of two edges. A rising edge gives no strobe.
- R8: Code 31 is single-step. A rising edge of `step_req` first sampled at edge k gives one strobe, in the cycle after edge k. Holding `step_req` high gives no further strobe.
- R9: In code 31, `fall_edge` has no effect on strobe timing.
- R10: In a divided code, the cycle after the edge that samples a code change has no strobe. The divider then restarts, so the phase set in R2 and R5 is measured from that change, not from the previous count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_code | input | 5 | Timebase code |
| fall_edge | input | 1 | Take samples on the falling side of the period |
| ext_clk | input | 1 | External sample clock, asynchronous |
| step_req | input | 1 | Manual single-step request, synchronous level |
| sample_stb | output | 1 | One-cycle sample-enable strobe |

## Verification
The latencies checked are fixed:
- In a divided code, the first strobe follows the second edge after the code change, plus floor(N/2) edges when `fall_edge` is 1.
- For the external clock, a strobe follows two edges after the edge that samples a transition of `ext_clk`.
- A step strobe follows the very edge that samples `step_req` rising.

A driver task numbers the edges and computes every strobe cycle from these rules, then queues them. A monitor samples at the falling clock edge and compares each strobe, and each expected strobe that does not appear, against the head of the queue. Each measurement runs only inside a window opened at the code change, so strobes from earlier modes cannot be counted.

// File: rtl/sample_timebase.sv
module sample_timebase #(
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] tb_code,
  input  logic       fall_edge,
  input  logic       ext_clk,
  input  logic       step_req,
  output logic       sample_stb
);

  localparam logic [4:0] CODE_EXT  = 5'd30;
  localparam logic [4:0] CODE_STEP = 5'd31;

  function automatic logic [CNT_W-1:0] ratio_of(input logic [4:0] c);
    case (c)
      5'd0:    ratio_of = CNT_W'(1);
      5'd1:    ratio_of = CNT_W'(2);
      5'd2:    ratio_of = CNT_W'(5);
      5'd3:    ratio_of = CNT_W'(10);
      5'd4:    ratio_of = CNT_W'(20);
      5'd5:    ratio_of = CNT_W'(50);
      5'd6:    ratio_of = CNT_W'(100);
      5'd7:    ratio_of = CNT_W'(200);
      5'd8:    ratio_of = CNT_W'(500);
      5'd9:    ratio_of = CNT_W'(1000);
      5'd10:   ratio_of = CNT_W'(2000);
      5'd11:   ratio_of = CNT_W'(5000);
      5'd12:   ratio_of = CNT_W'(10000);
      5'd13:   ratio_of = CNT_W'(20000);
      5'd14:   ratio_of = CNT_W'(50000);
      5'd15:   ratio_of = CNT_W'(100000);
      5'd16:   ratio_of = CNT_W'(200000);
      5'd17:   ratio_of = CNT_W'(500000);
      5'd18:   ratio_of = CNT_W'(1000000);
      CODE_EXT,
      CODE_STEP: ratio_of = CNT_W'(1);
      default: ratio_of = CNT_W'(2);
    endcase
  endfunction

  logic [4:0]       code_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] phase;
  logic [2:0]       ext_sh;
  logic             step_q;
  logic             code_chg;
  logic             ext_rise;
  logic             ext_fall;
  logic             stb_d;

  assign ratio    = ratio_of(tb_code);
  assign phase    = fall_edge ? (ratio >> 1) : '0;
  assign code_chg = (tb_code != code_q);
  assign ext_rise = ext_sh[1] & ~ext_sh[2];
  assign ext_fall = ~ext_sh[1] & ext_sh[2];

  always_comb begin
    case (tb_code)
      CODE_EXT:  stb_d = fall_edge ? ext_fall : ext_rise;
      CODE_STEP: stb_d = step_req & ~step_q;
      default:   stb_d = ~code_chg && (cnt == phase);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= '0;
      cnt        <= '0;
      ext_sh     <= '0;
      step_q     <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      code_q     <= tb_code;
      ext_sh     <= {ext_sh[1:0], ext_clk};
      step_q     <= step_req;
      sample_stb <= stb_d;
      if (code_chg || cnt >= ratio - CNT_W'(1))
        cnt <= '0;
      else
        cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

module sample_timebase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] tb_code,
  input logic       fall_edge,
  input logic       sample_stb
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!sample_stb);
  end

  // R3
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_code == 5'd0) ##1 (tb_code == 5'd0) |=> sample_stb);

  // R4
  div2_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (tb_code == 5'd1 || (tb_code >= 5'd19 && tb_code <= 5'd29))
     && $stable(tb_code) && $stable(fall_edge)) |=> !sample_stb);

  // R10
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_code != $past(tb_code) && tb_code < 5'd30) |=> !sample_stb);

  // R8
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && tb_code == 5'd31 && $stable(tb_code)) |=> !sample_stb);

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && tb_code == 5'd30 && $stable(tb_code) && $stable(fall_edge))
     |=> !sample_stb);

endmodule

bind sample_timebase sample_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tb_code(tb_code),
  .fall_edge(fall_edge), .sample_stb(sample_stb)
);

// File: tb/sample_timebase_bench.sv
module sample_timebase_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tb_code = 5'd1;
  logic       fall_edge = 1'b0;
  logic       ext_clk = 1'b0;
  logic       step_req = 1'b0;
  logic       sample_stb;

  sample_timebase u_sample_timebase (
    .clk(clk), .rst_n(rst_n), .tb_code(tb_code), .fall_edge(fall_edge),
    .ext_clk(ext_clk), .step_req(step_req), .sample_stb(sample_stb)
  );

  always #10 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  bit    mon_on = 1'b0;
  string tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bit hit;
    if (mon_on) begin
      hit = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (hit || sample_stb) begin
        n_chk++;
        if (hit != sample_stb) begin
          n_fail++;
          $display("FAIL %s: cycle %0d strobe=%0b expected %0b", tag, cyc, sample_stb, hit);
        end
      end
      if (hit) void'(exp_q.pop_front());
    end
  end

  function automatic int ratio_model(input logic [4:0] c);
    int m;
    int n;
    if (c >= 5'd30) return 1;
    if (c > 5'd18) return 2;
    m = (c % 3 == 0) ? 1 : (c % 3 == 1) ? 2 : 5;
    n = m;
    for (int d = 0; d < c / 3; d++) n = n * 10;
    return n;
  endfunction

  task automatic close_window();
    @(posedge clk);
    mon_on = 1'b0;
    exp_q.delete();
  endtask

  task automatic run_div(input logic [4:0] pre, input logic [4:0] code, input bit fe,
                         input int win, input string t);
    int e;
    int n;
    int tgt;
    @(negedge clk);
    tb_code = pre;
    fall_edge = 1'b0;
    repeat (7) @(negedge clk);
    tb_code = code;
    fall_edge = fe;
    tag = t;
    e = cyc + 1;
    n = ratio_model(code);
    tgt = fe ? n / 2 : 0;
    for (int s = e + 1 + tgt; s < e + win - 1; s += n) exp_q.push_back(s);
    mon_on = 1'b1;
    repeat (win) @(posedge clk);
    mon_on = 1'b0;
    exp_q.delete();
  endtask

  task automatic run_ext(input bit fe, input string t);
    int k;
    @(negedge clk);
    tb_code = 5'd30;
    fall_edge = fe;
    ext_clk = 1'b0;
    repeat (5) @(negedge clk);
    tag = t;
    mon_on = 1'b1;
    for (int p = 0; p < 2; p++) begin
      k = cyc + 1;
      exp_q.push_back(fe ? k + 5 + 2 : k + 2);
      ext_clk = 1'b1;
      repeat (5) @(negedge clk);
      ext_clk = 1'b0;
      repeat (6) @(negedge clk);
    end
    close_window();
  endtask

  task automatic run_step(input bit fe, input string t);
    int k;
    @(negedge clk);
    tb_code = 5'd31;
    fall_edge = fe;
    step_req = 1'b0;
    repeat (3) @(negedge clk);
    tag = t;
    mon_on = 1'b1;
    for (int p = 0; p < 2; p++) begin
      k = cyc + 1;
      exp_q.push_back(k);
      step_req = 1'b1;
      repeat (4) @(negedge clk);
      step_req = 1'b0;
      repeat (3) @(negedge clk);
    end
    close_window();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: cycle %0d reached, expected run end", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e;
    // R1: strobe low while reset held with a divided code
    repeat (4) begin
      @(negedge clk);
      n_chk++;
      if (sample_stb !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: strobe=%b expected 0 in reset", sample_stb);
      end
    end
    // R1 / R2: restart phase from reset release, code 1 (N=2)
    rst_n = 1'b1;
    tag = "R1 release";
    e = cyc + 1;
    for (int s = e + 1; s < e + 39; s += 2) exp_q.push_back(s);
    mon_on = 1'b1;
    repeat (40) @(posedge clk);
    mon_on = 1'b0;
    exp_q.delete();

    run_div(5'd31, 5'd0,  1'b0, 30,   "R3 code 0");
    run_div(5'd31, 5'd0,  1'b1, 30,   "R3 code 0 fall");
    run_div(5'd31, 5'd2,  1'b0, 60,   "R2 code 2");
    run_div(5'd31, 5'd3,  1'b0, 60,   "R2 code 3");
    run_div(5'd31, 5'd6,  1'b0, 450,  "R2 code 6");
    run_div(5'd31, 5'd18, 1'b0, 3000, "R2 code 18");
    run_div(5'd31, 5'd1,  1'b1, 40,   "R5 code 1 fall");
    run_div(5'd31, 5'd2,  1'b1, 60,   "R5 code 2 fall");
    run_div(5'd31, 5'd5,  1'b1, 200,  "R5 code 5 fall");
    run_div(5'd31, 5'd9,  1'b1, 2700, "R5 code 9 fall");
    run_div(5'd31, 5'd19, 1'b0, 40,   "R4 code 19");
    run_div(5'd31, 5'd25, 1'b1, 40,   "R4 code 25 fall");
    run_div(5'd31, 5'd29, 1'b0, 40,   "R4 code 29");
    run_div(5'd3,  5'd4,  1'b0, 100,  "R10 code 3 to 4");
    run_div(5'd5,  5'd3,  1'b1, 100,  "R10 code 5 to 3 fall");
    run_ext(1'b0, "R6 ext rise");
    run_ext(1'b1, "R7 ext fall");
    run_step(1'b0, "R8 step");
    run_step(1'b1, "R9 step fall ignored");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule